// File: doc/BRIEF.md
# Egress VLAN Tag Editor

This block sits on the byte stream leaving an egress port. For each packet it decides whether the 802.1Q tag is added, taken out, rewritten or left alone, and it makes that edit as the bytes go past. The decision depends on three things: the class of tag the packet arrived with, the kind of egress port (plain, access, hybrid or host-facing), and a small set of per-port control bits together with default VID and priority values. A separate table lookup supplies one un-tag bit, which applies to whichever VID the rules consult.

The data path adds no latency. Bytes flow straight through, guarded by valid/ready on both sides. The editor intervenes only at tag positions: bytes 12 to 15, counted from zero after the two 6-byte addresses. To insert a tag it holds off input for four output beats. To remove one it absorbs four input beats. To modify one it rewrites the two TCI bytes in place. The per-packet sideband is sampled on the first byte of each packet.

Top module: `vtag_egress_editor`

## Requirements
- R1: On a plain port (port_kind 0), untagged, priority-tagged and normal-tagged packets leave unchanged. Encodings: rx_class 0 means untagged, 1 means 802.1Q-tagged, 2 means host special tag, and 3 is handled as untagged. A tagged packet with rx_vid 0 is priority-tagged.
- R2: On an access port (port_kind 1), untagged packets pass unchanged, and every priority or normal tag is removed.
- R3: On a host-facing port (port_kind 3), every packet passes unchanged, whatever its class.
- R4: A packet with a host special tag has that tag removed on every port kind other than 3.
- R5: On a hybrid port (port_kind 2), an untagged packet receives a tag only when ctl_insert is 1 and untag_hit is 0. The tag is inserted at output bytes 12 to 15 as 0x81, 0x00, {ing_def_pcp, 1'b0, ing_def_vid[11:8]}, ing_def_vid[7:0]. Otherwise the packet passes unchanged.
- R6: On a hybrid port, a priority-tagged packet loses its tag when untag_hit is 1. Otherwise its VID becomes ing_def_vid, and its PCP becomes ing_def_pcp only when ctl_chg_pri is 1 (else the received PCP stays).
- R7: On a hybrid port, a normal-tagged packet loses its tag when untag_hit is 1. It passes unchanged when ctl_chg_tag is 0, or when ctl_chg_vid and ctl_chg_pri are both 0.
- R8: A rewrite alters only input bytes 14 and 15, which become {pcp, cfi, vid[11:8]} and vid[7:0]. The CFI bit (byte 14 bit 4) is kept from the stream. On the normal-tagged path, ctl_chg_vid selects egr_def_vid and ctl_chg_pri selects egr_def_pcp; each unselected field keeps its received value.
- R9: A tag removal drops exactly input bytes 12 to 15. All other bytes and the last flag leave in order.
- R10: An insertion holds in_ready low for exactly four output beats at byte position 12. If out_ready is low during insertion, the inserted byte is held. No other action stalls the input.
- R11: The sideband (class, VID, PCP, port kind, control bits, defaults, untag_hit) is taken on a packet's first accepted byte. Changes later in the same packet have no effect on its output.
- R12: After reset, with no input offered and out_ready high, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final byte of the packet |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can take a byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final output byte of the packet |
| rx_class | input | 2 | Received tag class (0 none, 1 802.1Q, 2 host special, 3 as none) |
| rx_vid | input | 12 | Received VID (0 marks priority-tagged) |
| rx_pcp | input | 3 | Received priority |
| port_kind | input | 2 | Egress port kind (0 plain, 1 access, 2 hybrid, 3 host) |
| ctl_insert | input | 1 | Hybrid: allow tag insertion |
| ctl_chg_tag | input | 1 | Hybrid: allow rewriting of normal tags |
| ctl_chg_vid | input | 1 | Hybrid: substitute egress default VID |
| ctl_chg_pri | input | 1 | Hybrid: substitute default priority |
| ing_def_vid | input | 12 | Ingress port default VID |
| ing_def_pcp | input | 3 | Ingress port default priority |
| egr_def_vid | input | 12 | Egress port default VID |
| egr_def_pcp | input | 3 | Egress port default priority |
| untag_hit | input | 1 | Un-tag bit from the VLAN lookup |

## Verification
Two situations can coincide in one cycle. First, the final beat of one packet is accepted on the same edge that the position counter wraps, and the next packet's first byte, carrying a different sideband, is latched on the following edge. The bench drives packets back to back with no idle gap, so every boundary exercises this. Second, insertion or removal can meet downstream back-pressure in the same cycle. The bench repeats insert, strip and rewrite packets under a periodic out_ready pattern. A scoreboard compares every output byte and last flag against a model computed independently of the design, and it counts input stalls in runs without back-pressure.

// File: rtl/vtag_pkg.sv
package vtag_pkg;
  localparam int TAG_BYTES = 4;
  localparam int VID_W     = 12;
  localparam int PCP_W     = 3;

  typedef enum logic [1:0] {RX_NONE = 2'd0, RX_DOT1Q = 2'd1, RX_HOST = 2'd2, RX_ALT = 2'd3} rx_class_e;
  typedef enum logic [1:0] {PK_PLAIN = 2'd0, PK_ACCESS = 2'd1, PK_HYBRID = 2'd2, PK_HOST = 2'd3} port_kind_e;
  typedef enum logic [1:0] {ACT_PASS = 2'd0, ACT_STRIP = 2'd1, ACT_INSERT = 2'd2, ACT_REWRITE = 2'd3} edit_act_e;

  typedef struct packed {
    logic ins;
    logic chg_tag;
    logic chg_vid;
    logic chg_pri;
  } egr_ctl_t;

  typedef struct packed {
    edit_act_e        act;
    logic [PCP_W-1:0] pcp;
    logic [VID_W-1:0] vid;
  } edit_plan_t;

  // Hybrid-port matrix: chooses the action and the tag fields it writes.
  function automatic edit_plan_t hybrid_plan(
    input rx_class_e cls, input logic [VID_W-1:0] rx_vid, input logic [PCP_W-1:0] rx_pcp,
    input egr_ctl_t ctl, input logic [VID_W-1:0] ivid, input logic [PCP_W-1:0] ipcp,
    input logic [VID_W-1:0] evid, input logic [PCP_W-1:0] epcp, input logic untag);
    edit_plan_t p;
    p.act = ACT_PASS;
    p.pcp = rx_pcp;
    p.vid = rx_vid;
    if (cls == RX_HOST) begin
      p.act = ACT_STRIP;
    end else if (cls == RX_DOT1Q) begin
      if (untag) p.act = ACT_STRIP;
      else if (rx_vid == '0) begin
        p.act = ACT_REWRITE;
        p.vid = ivid;
        if (ctl.chg_pri) p.pcp = ipcp;
      end else if (ctl.chg_tag && (ctl.chg_vid || ctl.chg_pri)) begin
        p.act = ACT_REWRITE;
        if (ctl.chg_vid) p.vid = evid;
        if (ctl.chg_pri) p.pcp = epcp;
      end
    end else begin
      if (ctl.ins && !untag) begin
        p.act = ACT_INSERT;
        p.vid = ivid;
        p.pcp = ipcp;
      end
    end
    return p;
  endfunction

  // Full class-by-port decision.
  function automatic edit_plan_t plan_edit(
    input rx_class_e cls, input logic [VID_W-1:0] rx_vid, input logic [PCP_W-1:0] rx_pcp,
    input port_kind_e kind, input egr_ctl_t ctl,
    input logic [VID_W-1:0] ivid, input logic [PCP_W-1:0] ipcp,
    input logic [VID_W-1:0] evid, input logic [PCP_W-1:0] epcp, input logic untag);
    edit_plan_t p;
    p.act = ACT_PASS;
    p.pcp = rx_pcp;
    p.vid = rx_vid;
    case (kind)
      PK_PLAIN:  if (cls == RX_HOST) p.act = ACT_STRIP;
      PK_ACCESS: if (cls == RX_HOST || cls == RX_DOT1Q) p.act = ACT_STRIP;
      PK_HYBRID: p = hybrid_plan(cls, rx_vid, rx_pcp, ctl, ivid, ipcp, evid, epcp, untag);
      default:   p.act = ACT_PASS;
    endcase
    return p;
  endfunction

  // Byte idx of a freshly built tag.
  function automatic logic [7:0] tag_byte(input logic [1:0] idx, input logic [15:0] tpid,
                                          input logic [PCP_W-1:0] pcp, input logic [VID_W-1:0] vid);
    logic [7:0] b;
    case (idx)
      2'd0:    b = tpid[15:8];
      2'd1:    b = tpid[7:0];
      2'd2:    b = {pcp, 1'b0, vid[11:8]};
      default: b = vid[7:0];
    endcase
    return b;
  endfunction
endpackage

// File: rtl/vtag_policy.sv
module vtag_policy
  import vtag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  rx_class_e        cls,
  input  logic [VID_W-1:0] rx_vid,
  input  logic [PCP_W-1:0] rx_pcp,
  input  port_kind_e       kind,
  input  egr_ctl_t         ctl,
  input  logic [VID_W-1:0] ivid,
  input  logic [PCP_W-1:0] ipcp,
  input  logic [VID_W-1:0] evid,
  input  logic [PCP_W-1:0] epcp,
  input  logic             untag,
  output edit_plan_t       plan
);
  always_comb plan = plan_edit(cls, rx_vid, rx_pcp, kind, ctl, ivid, ipcp, evid, epcp, untag);

  p_host_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == PK_HOST) |-> (plan.act == ACT_PASS));
  p_special_strip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == RX_HOST && kind != PK_HOST) |-> (plan.act == ACT_STRIP));
  p_access_strip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == PK_ACCESS && cls == RX_DOT1Q) |-> (plan.act == ACT_STRIP));
  p_plain_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == PK_PLAIN && cls != RX_HOST) |-> (plan.act == ACT_PASS));
endmodule

// File: rtl/vtag_position.sv
module vtag_position #(
  parameter int LIMIT = 16,
  parameter int POS_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             last,
  output logic [POS_W-1:0] pos,
  output logic             sop
);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= '0;
    else if (fire) begin
      if (last) pos <= '0;
      else if (pos != POS_MAX) pos <= pos + 1'b1;
    end
  end

  assign sop = (pos == '0);

  p_pos_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last && pos != POS_MAX) |=> (pos == $past(pos) + 1'b1));
  p_pos_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last) |=> sop);
  p_pos_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire) |=> $stable(pos));
endmodule

// File: rtl/vtag_edit_path.sv
module vtag_edit_path
  import vtag_pkg::*;
#(
  parameter int          ADDR_BYTES = 12,
  parameter logic [15:0] TPID       = 16'h8100,
  parameter int          POS_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  edit_plan_t       plan_now,
  input  logic [POS_W-1:0] pos,
  input  logic             sop,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last
);
  localparam int CNT_W = $clog2(TAG_BYTES + 1);
  localparam logic [POS_W-1:0] P_TAG0 = POS_W'(ADDR_BYTES);
  localparam logic [POS_W-1:0] P_TCIH = POS_W'(ADDR_BYTES + 2);
  localparam logic [POS_W-1:0] P_TCIL = POS_W'(ADDR_BYTES + 3);
  localparam logic [POS_W-1:0] P_END  = POS_W'(ADDR_BYTES + TAG_BYTES);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(TAG_BYTES);

  edit_plan_t       plan_q;
  edit_plan_t       plan_use;
  logic [CNT_W-1:0] ins_cnt;
  logic             in_fire;
  logic             in_tag_win;
  logic             ins_active;
  logic             drop_beat;
  logic             rw_hi;
  logic             rw_lo;

  assign plan_use   = sop ? plan_now : plan_q;
  assign in_tag_win = (pos >= P_TAG0) && (pos < P_END);
  assign ins_active = (plan_use.act == ACT_INSERT) && (pos == P_TAG0) && (ins_cnt != CNT_FULL);
  assign drop_beat  = (plan_use.act == ACT_STRIP) && in_tag_win;
  assign rw_hi      = (plan_use.act == ACT_REWRITE) && (pos == P_TCIH);
  assign rw_lo      = (plan_use.act == ACT_REWRITE) && (pos == P_TCIL);
  assign in_fire    = in_valid && in_ready;

  always_comb begin
    out_valid = in_valid;
    in_ready  = out_ready;
    out_data  = in_data;
    out_last  = in_last;
    if (ins_active) begin
      out_valid = 1'b1;
      in_ready  = 1'b0;
      out_data  = tag_byte(ins_cnt[1:0], TPID, plan_use.pcp, plan_use.vid);
      out_last  = 1'b0;
    end else if (drop_beat) begin
      out_valid = 1'b0;
      in_ready  = 1'b1;
      out_last  = 1'b0;
    end else if (rw_hi) begin
      out_data = {plan_use.pcp, in_data[4], plan_use.vid[11:8]};
    end else if (rw_lo) begin
      out_data = plan_use.vid[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) plan_q <= '0;
    else if (in_fire && sop) plan_q <= plan_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ins_cnt <= '0;
    else if (in_fire && in_last) ins_cnt <= '0;
    else if (ins_active && out_ready) ins_cnt <= ins_cnt + 1'b1;
  end

  p_ins_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ins_cnt <= CNT_FULL);
  p_ins_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_active && !out_ready) |=> (out_valid && $stable(out_data)));
  p_plan_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_fire && sop) |=> $stable(plan_q));
  p_ins_no_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_active && out_ready) |=> (pos == $past(pos)));
endmodule

// File: rtl/vtag_egress_editor.sv
module vtag_egress_editor
  import vtag_pkg::*;
#(
  parameter int          ADDR_BYTES = 12,
  parameter logic [15:0] TPID       = 16'h8100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last,
  input  logic [1:0]  rx_class,
  input  logic [11:0] rx_vid,
  input  logic [2:0]  rx_pcp,
  input  logic [1:0]  port_kind,
  input  logic        ctl_insert,
  input  logic        ctl_chg_tag,
  input  logic        ctl_chg_vid,
  input  logic        ctl_chg_pri,
  input  logic [11:0] ing_def_vid,
  input  logic [2:0]  ing_def_pcp,
  input  logic [11:0] egr_def_vid,
  input  logic [2:0]  egr_def_pcp,
  input  logic        untag_hit
);
  localparam int POS_LIMIT = ADDR_BYTES + TAG_BYTES;
  localparam int POS_W     = $clog2(POS_LIMIT + 1);

  edit_plan_t       plan_now;
  egr_ctl_t         ctl;
  logic [POS_W-1:0] pos;
  logic             sop;
  logic             in_fire;

  assign ctl     = '{ins: ctl_insert, chg_tag: ctl_chg_tag, chg_vid: ctl_chg_vid, chg_pri: ctl_chg_pri};
  assign in_fire = in_valid && in_ready;

  vtag_policy u_policy (
    .clk   (clk),
    .rst_n (rst_n),
    .cls   (rx_class_e'(rx_class)),
    .rx_vid(rx_vid),
    .rx_pcp(rx_pcp),
    .kind  (port_kind_e'(port_kind)),
    .ctl   (ctl),
    .ivid  (ing_def_vid),
    .ipcp  (ing_def_pcp),
    .evid  (egr_def_vid),
    .epcp  (egr_def_pcp),
    .untag (untag_hit),
    .plan  (plan_now)
  );

  vtag_position #(.LIMIT(POS_LIMIT), .POS_W(POS_W)) u_pos (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (in_fire),
    .last (in_last),
    .pos  (pos),
    .sop  (sop)
  );

  vtag_edit_path #(.ADDR_BYTES(ADDR_BYTES), .TPID(TPID), .POS_W(POS_W)) u_edit (
    .clk      (clk),
    .rst_n    (rst_n),
    .plan_now (plan_now),
    .pos      (pos),
    .sop      (sop),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .in_last  (in_last),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_last (out_last)
  );

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && pos != POS_W'(ADDR_BYTES)) |-> !out_valid);
endmodule

// File: tb/tb_vtag_egress_editor.sv
module tb_vtag_egress_editor;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;
  logic [1:0] rx_class = '0, port_kind = '0;
  logic [11:0] rx_vid = '0, ing_def_vid = '0, egr_def_vid = '0;
  logic [2:0] rx_pcp = '0, ing_def_pcp = '0, egr_def_pcp = '0;
  logic ctl_insert = 0, ctl_chg_tag = 0, ctl_chg_vid = 0, ctl_chg_pri = 0, untag_hit = 0;

  logic [7:0] exp_q[$];
  logic       exp_last_q[$];
  string      req_q[$];
  int errors = 0, checks = 0, cyc = 0;
  bit bp_on = 0;
  logic [7:0] m_e;
  logic       m_l;
  string      m_r;

  vtag_egress_editor dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always begin
    @(posedge clk); #1;
    out_ready = bp_on ? ((cyc % 3) != 1) : 1'b1;
  end

  // Monitor: pops expected bytes on each output transfer.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected output byte %02h expected none", out_data);
      end else begin
        m_e = exp_q.pop_front();
        m_l = exp_last_q.pop_front();
        m_r = req_q.pop_front();
        if (out_data !== m_e || out_last !== m_l) begin
          errors++;
          $display("FAIL %s data=%02h last=%0b expected data=%02h last=%0b", m_r, out_data, out_last, m_e, m_l);
        end
      end
    end
  end

  // Independent reference decision: act 0 pass, 1 strip, 2 insert, 3 rewrite.
  function automatic void model(input int cls, input int vid, input int pcp, input int kind,
      input bit ins, input bit ctag, input bit cvid, input bit cpri,
      input int ivid, input int ipcp, input int evid, input int epcp, input bit untag,
      output int act, output int npcp, output int nvid);
    act = 0; npcp = pcp; nvid = vid;
    if (kind == 3) act = 0;
    else if (cls == 2) act = 1;
    else if (kind == 0) act = 0;
    else if (kind == 1) act = (cls == 1) ? 1 : 0;
    else if (cls != 1) begin
      if (ins && !untag) begin act = 2; nvid = ivid; npcp = ipcp; end
    end else if (untag) act = 1;
    else if (vid == 0) begin act = 3; nvid = ivid; if (cpri) npcp = ipcp; end
    else if (ctag && (cvid || cpri)) begin
      act = 3;
      if (cvid) nvid = evid;
      if (cpri) npcp = epcp;
    end
  endfunction

  task automatic push_exp(input logic [7:0] b, input logic l, input string req);
    exp_q.push_back(b); exp_last_q.push_back(l); req_q.push_back(req);
  endtask

  task automatic send_pkt(input int cls, input int vid, input int pcp, input bit cfi, input int kind,
      input bit ins, input bit ctag, input bit cvid, input bit cpri,
      input int ivid, input int ipcp, input int evid, input int epcp, input bit untag,
      input int plen, input string req, input bit perturb);
    logic [7:0] pkt[$];
    int act, npcp, nvid, stall, exp_stall, n;
    bit acc;
    for (int i = 0; i < 12; i++) pkt.push_back(8'(8'h20 + i * 5 + plen));
    if (cls == 1) begin
      pkt.push_back(8'h81); pkt.push_back(8'h00);
      pkt.push_back({3'(pcp), cfi, 4'(vid >> 8)}); pkt.push_back(8'(vid));
    end else if (cls == 2) begin
      pkt.push_back(8'hA5); pkt.push_back(8'h0F); pkt.push_back(8'h3C); pkt.push_back(8'h96);
    end
    for (int i = 0; i < plen; i++) pkt.push_back(8'(i * 7 + 3));
    n = pkt.size();
    model(cls, vid, pcp, kind, ins, ctag, cvid, cpri, ivid, ipcp, evid, epcp, untag, act, npcp, nvid);
    for (int i = 0; i < n; i++) begin
      if (act == 2 && i == 12) begin
        push_exp(8'h81, 1'b0, req); push_exp(8'h00, 1'b0, req);
        push_exp({3'(npcp), 1'b0, 4'(nvid >> 8)}, 1'b0, req); push_exp(8'(nvid), 1'b0, req);
      end
      if (act == 1 && i >= 12 && i < 16) continue;
      if (act == 3 && i == 14) push_exp({3'(npcp), pkt[i][4], 4'(nvid >> 8)}, i == n - 1, req);
      else if (act == 3 && i == 15) push_exp(8'(nvid), i == n - 1, req);
      else push_exp(pkt[i], i == n - 1, req);
    end
    rx_class = 2'(cls); rx_vid = 12'(vid); rx_pcp = 3'(pcp); port_kind = 2'(kind);
    ctl_insert = ins; ctl_chg_tag = ctag; ctl_chg_vid = cvid; ctl_chg_pri = cpri;
    ing_def_vid = 12'(ivid); ing_def_pcp = 3'(ipcp); egr_def_vid = 12'(evid); egr_def_pcp = 3'(epcp);
    untag_hit = untag;
    stall = 0;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = pkt[i]; in_last = (i == n - 1);
      acc = 0;
      while (!acc) begin
        @(negedge clk);
        if (!in_ready && out_ready) stall++;
        acc = in_ready;
        @(posedge clk); #1;
      end
      if (i == 0 && perturb) begin
        rx_class = ~rx_class; rx_vid = ~rx_vid; rx_pcp = ~rx_pcp; port_kind = ~port_kind;
        ctl_insert = ~ctl_insert; ctl_chg_tag = ~ctl_chg_tag; ctl_chg_vid = ~ctl_chg_vid;
        ctl_chg_pri = ~ctl_chg_pri; ing_def_vid = ~ing_def_vid; egr_def_vid = ~egr_def_vid;
        untag_hit = ~untag_hit;
      end
    end
    if (!bp_on) begin
      exp_stall = (act == 2) ? 4 : 0;
      checks++;
      if (stall != exp_stall) begin
        errors++;
        $display("FAIL R10 (%s) stall cycles=%0d expected=%0d", req, stall, exp_stall);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R12 watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R12 reset out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(posedge clk); #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R12 idle out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
    end
    // cls vid pcp cfi kind ins ctag cvid cpri ivid ipcp evid epcp untag plen req perturb
    send_pkt(0, 0,     0, 0, 0, 1, 1, 1, 1, 12'h055, 2, 12'h077, 4, 0, 6, "R1 plain untagged", 0);
    send_pkt(1, 12'h123, 5, 0, 0, 1, 1, 1, 1, 12'h055, 2, 12'h077, 4, 1, 5, "R1 plain normal", 0);
    send_pkt(1, 0,     6, 1, 0, 1, 1, 1, 1, 12'h055, 2, 12'h077, 4, 1, 5, "R1 plain priority", 0);
    send_pkt(2, 12'h321, 1, 0, 0, 0, 0, 0, 0, 12'h055, 2, 12'h077, 4, 0, 5, "R4 plain special", 0);
    send_pkt(0, 0,     0, 0, 1, 1, 1, 1, 1, 12'h011, 3, 12'h022, 5, 0, 4, "R2 access untagged", 0);
    send_pkt(1, 12'h456, 2, 0, 1, 0, 0, 0, 0, 12'h011, 3, 12'h022, 5, 0, 5, "R2 access normal", 0);
    send_pkt(1, 0,     7, 0, 1, 0, 0, 0, 0, 12'h011, 3, 12'h022, 5, 0, 5, "R2 access priority", 0);
    send_pkt(2, 12'h001, 0, 0, 1, 0, 0, 0, 0, 12'h011, 3, 12'h022, 5, 0, 4, "R4 access special", 0);
    send_pkt(0, 0,     0, 0, 3, 1, 1, 1, 1, 12'h0AA, 1, 12'h0BB, 6, 0, 5, "R3 host untagged", 0);
    send_pkt(1, 12'h789, 3, 1, 3, 1, 1, 1, 1, 12'h0AA, 1, 12'h0BB, 6, 1, 5, "R3 host normal", 0);
    send_pkt(2, 12'h789, 3, 0, 3, 1, 1, 1, 1, 12'h0AA, 1, 12'h0BB, 6, 1, 5, "R3 host special", 0);
    send_pkt(0, 0,     0, 0, 2, 1, 0, 0, 0, 12'hABC, 5, 12'h0BB, 6, 0, 5, "R5 hybrid insert", 0);
    send_pkt(0, 0,     0, 0, 2, 1, 0, 0, 0, 12'hABC, 5, 12'h0BB, 6, 1, 5, "R5 hybrid untag blocks insert", 0);
    send_pkt(3, 0,     0, 0, 2, 0, 0, 0, 0, 12'hABC, 5, 12'h0BB, 6, 0, 5, "R5 hybrid insert disabled", 0);
    send_pkt(1, 0,     4, 1, 2, 0, 0, 0, 0, 12'h3E1, 2, 12'h0BB, 6, 1, 5, "R6 hybrid priority strip", 0);
    send_pkt(1, 0,     4, 1, 2, 0, 0, 0, 0, 12'h3E1, 2, 12'h0BB, 6, 0, 5, "R6 hybrid priority keep pcp", 0);
    send_pkt(1, 0,     4, 0, 2, 0, 0, 0, 1, 12'h3E1, 2, 12'h0BB, 6, 0, 5, "R6 hybrid priority new pcp", 0);
    send_pkt(1, 12'h5A5, 3, 0, 2, 0, 1, 1, 1, 12'h111, 1, 12'h222, 6, 1, 5, "R7 hybrid normal strip", 0);
    send_pkt(1, 12'h5A5, 3, 0, 2, 0, 0, 1, 1, 12'h111, 1, 12'h222, 6, 0, 5, "R7 hybrid change-tag clear", 0);
    send_pkt(1, 12'h5A5, 3, 0, 2, 0, 1, 0, 0, 12'h111, 1, 12'h222, 6, 0, 5, "R7 hybrid no field change", 0);
    send_pkt(1, 12'h5A5, 3, 1, 2, 0, 1, 1, 0, 12'h111, 1, 12'h222, 6, 0, 5, "R8 hybrid vid only", 0);
    send_pkt(1, 12'h5A5, 3, 0, 2, 0, 1, 0, 1, 12'h111, 1, 12'h222, 6, 0, 5, "R8 hybrid pcp only", 0);
    send_pkt(1, 12'hFFE, 0, 1, 2, 0, 1, 1, 1, 12'h111, 1, 12'h222, 7, 0, 5, "R8 hybrid both keep cfi", 0);
    send_pkt(2, 12'h5A5, 3, 0, 2, 1, 1, 1, 1, 12'h111, 1, 12'h222, 6, 0, 5, "R4 hybrid special", 0);
    send_pkt(1, 12'h456, 2, 0, 1, 0, 0, 0, 0, 12'h011, 3, 12'h022, 5, 0, 1, "R9 strip short tail", 0);
    send_pkt(0, 0,     0, 0, 2, 1, 0, 0, 0, 12'hD0D, 6, 12'h0BB, 6, 0, 5, "R11 insert sideband moved", 1);
    send_pkt(2, 12'h100, 2, 0, 0, 0, 0, 0, 0, 12'h055, 2, 12'h077, 4, 0, 5, "R11 strip sideband moved", 1);
    bp_on = 1;
    send_pkt(0, 0,     0, 0, 2, 1, 0, 0, 0, 12'h9C3, 3, 12'h0BB, 6, 0, 6, "R10 insert under backpressure", 0);
    send_pkt(1, 12'h456, 2, 0, 1, 0, 0, 0, 0, 12'h011, 3, 12'h022, 5, 0, 6, "R9 strip under backpressure", 0);
    send_pkt(1, 12'h5A5, 3, 1, 2, 0, 1, 1, 1, 12'h111, 1, 12'h222, 6, 0, 6, "R8 rewrite under backpressure", 0);
    send_pkt(0, 0,     0, 0, 2, 1, 0, 0, 0, 12'h9C3, 3, 12'h0BB, 6, 0, 4, "R5 insert back to back", 0);
    in_valid = 1'b0; in_last = 1'b0;
    bp_on = 0;
    for (int k = 0; k < 200 && exp_q.size() != 0; k++) @(posedge clk);
    repeat (2) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 missing output bytes actual=%0d pending expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule